// File: doc/BRIEF.md
# Interleaved Cache-Line Refill Responder

The block answers cache-line refill requests from a set of internal memory banks. A requester presents a line address for one bus cycle while the block is idle. Every bank starts reading its word of that line in the same cycle. After a fixed access latency, the words come back to the requester.

In interleaved mode the words are returned one per bus cycle, from bank 0 upward. In wide mode the whole line is returned in a single transfer cycle. With four banks and a 15-cycle access, the miss penalty is 1 + 15 + 4 = 20 cycles interleaved and 1 + 15 + 1 = 17 cycles wide. A compile-time parameter selects the mode, so the two organisations can be compared.

The block measures the penalty of every request itself. It reports the count on the cycle that completes the line.

Top module: `line_refill_responder`

## Requirements
- R1: While reset is held and after its release with no request, `busy`, `rsp_valid`, `rsp_last` and `pen_valid` are low.
- R2: A request is taken when `req_valid` is high and `busy` is low at a rising edge. That cycle is address cycle 1, and `busy` is high from the next cycle on.
- R3: While `busy` is high, `req_valid` and `req_line` have no effect: the words returned and the penalty count stay those of the accepted request.
- R4: The first response cycle is cycle ACCESS_LAT + 2, counting the address cycle as cycle 1. With the default latency of 15 this is cycle 17.
- R5: In interleaved mode, NUM_BANKS response cycles follow back to back. `rsp_idx` steps 0, 1, 2, ... and the word sits in `rsp_data[WORD_W-1:0]` with all upper bits zero.
- R6: Word b of line L is held in bank b. Its value is the low WORD_W bits of ((L*256 + b) * 0x9E3779B1 mod 2^32) XOR 0xC3C3C3C3.
- R7: `rsp_last` is high in exactly the final response cycle of a request. `busy` is low in the cycle after it.
- R8: In wide mode there is one response cycle, with `rsp_idx` = 0 and `rsp_last` high. Word b sits in `rsp_data[b*WORD_W +: WORD_W]`.
- R9: `pen_valid` is high with `rsp_last`, and `pen_cycles` then equals 1 + ACCESS_LAT + transfers. That is 20 for four interleaved banks and 17 for wide mode.
- R10: A request raised in the first cycle with `busy` low is accepted at once, with no idle gap required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line request strobe |
| req_line | input | LINE_AW | Line (block) address |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | Response word(s) present this cycle |
| rsp_idx | output | IDX_W | Word index of the response |
| rsp_last | output | 1 | Final response of the line |
| rsp_data | output | NUM_BANKS*WORD_W | Response data |
| pen_valid | output | 1 | Penalty count valid |
| pen_cycles | output | PEN_W | Measured miss penalty in bus cycles |

## Verification
The bench runs one interleaved instance and one wide instance side by side. It sends the lowest and highest line addresses, and then random lines, with no gap between requests. It also drives random requests while each instance is busy.

If the access counter were off by one, the first word would arrive one cycle early or late, and the penalty would read 19 or 21 rather than 20. If the word order were wrong, the index and data would disagree with the bank formula. If a request were taken while busy, the line and its data would be swapped partway through. If busy were released late, the request sent in the next cycle would be dropped and the following data would be lost.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_XFER   = 2'd2
  } refill_state_e;

  // contents of a bank word: hashed from line and bank number
  function automatic logic [31:0] seed_word(input int unsigned line, input int unsigned bank);
    logic [31:0] key;
    key = 32'((line << 8) | bank);
    return (key * 32'h9E37_79B1) ^ 32'hC3C3_C3C3;
  endfunction

  // number of transfer cycles per line
  function automatic int unsigned xfer_count(input bit wide, input int unsigned banks);
    return wide ? 1 : banks;
  endfunction

  // address cycle + access latency + transfers
  function automatic int unsigned miss_penalty(input bit wide, input int unsigned banks,
                                               input int unsigned lat);
    return 1 + lat + xfer_count(wide, banks);
  endfunction

endpackage

// File: rtl/refill_bank.sv
module refill_bank
  import refill_pkg::*;
#(
  parameter int unsigned BANK_ID = 0,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned LINE_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LINE_AW-1:0] line,
  output logic [WORD_W-1:0]  rd_word
);
  localparam int unsigned DEPTH = 1 << LINE_AW;

  logic [WORD_W-1:0] mem [DEPTH];

  // storage is seeded on reset; the access latches the word at start
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int unsigned i = 0; i < DEPTH; i++) begin
        mem[i[LINE_AW-1:0]] <= WORD_W'(seed_word(i, BANK_ID));
      end
      rd_word <= '0;
    end else if (start) begin
      rd_word <= mem[line];
    end
  end

endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
#(
  parameter int unsigned NUM_XFER   = 4,
  parameter int unsigned ACCESS_LAT = 15,
  parameter int unsigned IDX_W      = 2,
  parameter int unsigned PEN_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             busy,
  output logic             accept_evt,
  output logic             access_done_evt,
  output logic             xfer_active,
  output logic [IDX_W-1:0] xfer_idx,
  output logic             xfer_last,
  output logic [PEN_W-1:0] cyc_now
);
  localparam int unsigned LAT_W = $clog2(ACCESS_LAT + 1);

  refill_state_e    state_q;
  logic [LAT_W-1:0] lat_q;
  logic [IDX_W-1:0] idx_q;
  logic [PEN_W-1:0] cyc_q;

  assign busy            = (state_q != ST_IDLE);
  assign accept_evt      = req_valid && (state_q == ST_IDLE);
  assign access_done_evt = (state_q == ST_ACCESS) && (lat_q == LAT_W'(ACCESS_LAT - 1));
  assign xfer_active     = (state_q == ST_XFER);
  assign xfer_idx        = idx_q;
  assign xfer_last       = xfer_active && (idx_q == IDX_W'(NUM_XFER - 1));
  assign cyc_now         = cyc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lat_q   <= '0;
      idx_q   <= '0;
      cyc_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_evt) begin
            state_q <= ST_ACCESS;
            lat_q   <= '0;
            cyc_q   <= PEN_W'(2);
          end
        end
        ST_ACCESS: begin
          cyc_q <= cyc_q + 1'b1;
          if (access_done_evt) begin
            state_q <= ST_XFER;
            idx_q   <= '0;
          end else begin
            lat_q <= lat_q + 1'b1;
          end
        end
        ST_XFER: begin
          cyc_q <= cyc_q + 1'b1;
          if (xfer_last) state_q <= ST_IDLE;
          else           idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/refill_lane_pack.sv
module refill_lane_pack #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned IDX_W     = 2,
  parameter bit          WIDE      = 1'b0
) (
  input  logic [NUM_BANKS*WORD_W-1:0] bank_words,
  input  logic [IDX_W-1:0]            idx,
  input  logic                        active,
  output logic [NUM_BANKS*WORD_W-1:0] line_out
);
  localparam int unsigned LINE_W = NUM_BANKS * WORD_W;

  generate
    if (WIDE) begin : g_wide
      logic unused_idx;
      assign unused_idx = ^idx;
      assign line_out   = active ? bank_words : '0;
    end else begin : g_narrow
      logic [WORD_W-1:0] pick;
      always_comb begin
        pick = '0;
        for (int unsigned b = 0; b < NUM_BANKS; b++) begin
          if (idx == IDX_W'(b)) pick = bank_words[b*WORD_W +: WORD_W];
        end
      end
      assign line_out = active ? LINE_W'(pick) : '0;
    end
  endgenerate

endmodule

// File: rtl/line_refill_responder.sv
module line_refill_responder
  import refill_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned LINE_AW    = 6,
  parameter int unsigned ACCESS_LAT = 15,
  parameter bit          WIDE       = 1'b0,
  parameter int unsigned IDX_W      = $clog2(NUM_BANKS),
  parameter int unsigned PEN_W      = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [LINE_AW-1:0]          req_line,
  output logic                        busy,
  output logic                        rsp_valid,
  output logic [IDX_W-1:0]            rsp_idx,
  output logic                        rsp_last,
  output logic [NUM_BANKS*WORD_W-1:0] rsp_data,
  output logic                        pen_valid,
  output logic [PEN_W-1:0]            pen_cycles
);
  localparam int unsigned NUM_XFER = xfer_count(WIDE, NUM_BANKS);

  logic                        accept_evt;
  logic                        access_done_evt;
  logic                        xfer_active;
  logic                        xfer_last;
  logic [IDX_W-1:0]            xfer_idx;
  logic [PEN_W-1:0]            cyc_now;
  logic [NUM_BANKS*WORD_W-1:0] bank_words;

  refill_ctrl #(
    .NUM_XFER  (NUM_XFER),
    .ACCESS_LAT(ACCESS_LAT),
    .IDX_W     (IDX_W),
    .PEN_W     (PEN_W)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .busy           (busy),
    .accept_evt     (accept_evt),
    .access_done_evt(access_done_evt),
    .xfer_active    (xfer_active),
    .xfer_idx       (xfer_idx),
    .xfer_last      (xfer_last),
    .cyc_now        (cyc_now)
  );

  // all banks start together on the accepted address
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    refill_bank #(
      .BANK_ID(b),
      .WORD_W (WORD_W),
      .LINE_AW(LINE_AW)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept_evt),
      .line   (req_line),
      .rd_word(bank_words[b*WORD_W +: WORD_W])
    );
  end

  refill_lane_pack #(
    .NUM_BANKS(NUM_BANKS),
    .WORD_W   (WORD_W),
    .IDX_W    (IDX_W),
    .WIDE     (WIDE)
  ) u_pack (
    .bank_words(bank_words),
    .idx       (xfer_idx),
    .active    (xfer_active),
    .line_out  (rsp_data)
  );

  assign rsp_valid  = xfer_active;
  assign rsp_idx    = xfer_active ? xfer_idx : '0;
  assign rsp_last   = xfer_last;
  assign pen_valid  = xfer_last;
  assign pen_cycles = xfer_last ? cyc_now : '0;

endmodule

// File: rtl/refill_checker.sv
module refill_checker #(
  parameter int unsigned ACCESS_LAT = 15,
  parameter bit          WIDE       = 1'b0,
  parameter int unsigned IDX_W      = 2,
  parameter int unsigned PEN_W      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept_evt,
  input logic             busy,
  input logic             rsp_valid,
  input logic [IDX_W-1:0] rsp_idx,
  input logic             rsp_last,
  input logic             pen_valid,
  input logic [PEN_W-1:0] pen_cycles
);
  // independent cycle number within the current request
  logic [15:0] chk_cyc;
  always_ff @(posedge clk) begin
    if (!rst_n)          chk_cyc <= '0;
    else if (accept_evt) chk_cyc <= 16'd2;
    else if (busy)       chk_cyc <= chk_cyc + 16'd1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rsp_valid && !pen_valid));

  // R2
  accept_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy);

  // R3
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_last) |=> busy);

  // R4
  first_word_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (chk_cyc == 16'(ACCESS_LAT + 2)));

  // R5
  ascending_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last) |=> (rsp_valid && rsp_idx == $past(rsp_idx) + 1'b1));

  // R7
  last_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |=> !busy);

  // R7
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);

  // R9
  penalty_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pen_valid |-> (16'(pen_cycles) == chk_cyc));

  generate
    if (WIDE) begin : g_wide_chk
      // R8
      single_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_last && rsp_idx == '0));
    end
  endgenerate

endmodule

bind line_refill_responder refill_checker #(
  .ACCESS_LAT(ACCESS_LAT),
  .WIDE      (WIDE),
  .IDX_W     (IDX_W),
  .PEN_W     (PEN_W)
) u_refill_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept_evt(accept_evt),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .rsp_idx   (rsp_idx),
  .rsp_last  (rsp_last),
  .pen_valid (pen_valid),
  .pen_cycles(pen_cycles)
);

// File: tb/test_line_refill_responder.sv
module test_line_refill_responder;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 4;
  localparam int WW   = 32;
  localparam int AW   = 6;
  localparam int LAT  = 15;
  localparam int IW   = 2;
  localparam int PW   = 8;
  localparam int LW   = NB * WW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_line = '0;

  logic n_busy, n_valid, n_last, n_pv;
  logic [IW-1:0] n_idx;
  logic [LW-1:0] n_data;
  logic [PW-1:0] n_pc;
  logic w_busy, w_valid, w_last, w_pv;
  logic [IW-1:0] w_idx;
  logic [LW-1:0] w_data;
  logic [PW-1:0] w_pc;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_refill_responder #(.NUM_BANKS(NB), .WORD_W(WW), .LINE_AW(AW),
    .ACCESS_LAT(LAT), .WIDE(1'b0)) i_line_refill_responder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
    .busy(n_busy), .rsp_valid(n_valid), .rsp_idx(n_idx), .rsp_last(n_last),
    .rsp_data(n_data), .pen_valid(n_pv), .pen_cycles(n_pc));

  line_refill_responder #(.NUM_BANKS(NB), .WORD_W(WW), .LINE_AW(AW),
    .ACCESS_LAT(LAT), .WIDE(1'b1)) i_line_refill_responder_wide (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
    .busy(w_busy), .rsp_valid(w_valid), .rsp_idx(w_idx), .rsp_last(w_last),
    .rsp_data(w_data), .pen_valid(w_pv), .pen_cycles(w_pc));

  // R6: bank word formula, restated with 64-bit arithmetic
  function automatic logic [WW-1:0] exp_word(input int line, input int bank);
    longint unsigned p;
    p = (longint'(line) * 256 + longint'(bank)) * 64'd2654435761;
    return WW'(p[31:0] ^ 32'hC3C3C3C3);
  endfunction

  function automatic logic [LW-1:0] exp_line(input int line);
    logic [LW-1:0] v;
    for (int b = 0; b < NB; b++) v[b*WW +: WW] = exp_word(line, b);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                     input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // checks one instance in request cycle k (address cycle = 1)
  task automatic check_cycle(input bit wide, input int k, input int line,
      input logic busy, input logic valid, input logic [IW-1:0] idx,
      input logic last, input logic [LW-1:0] data, input logic pv,
      input logic [PW-1:0] pc);
    int nx, first, lastc, pen;
    bit ev;
    nx    = wide ? 1 : NB;
    first = LAT + 2;
    lastc = first + nx - 1;
    pen   = 1 + LAT + nx;
    ev    = (k >= first) && (k <= lastc);
    chk(busy == (k <= lastc), wide ? "R8 R7 busy window" : "R7 R2 busy window", LW'(busy), LW'(k <= lastc));
    chk(valid == ev, "R4 response timing", LW'(valid), LW'(ev));
    chk(last == (k == lastc), "R7 last flag", LW'(last), LW'(k == lastc));
    chk(pv == (k == lastc), "R9 penalty strobe", LW'(pv), LW'(k == lastc));
    if (k == lastc) chk(int'(pc) == pen, "R9 penalty count", LW'(pc), LW'(pen));
    if (ev) begin
      if (wide) begin
        chk(idx == '0, "R8 wide index", LW'(idx), '0);
        chk(data == exp_line(line), "R8 R6 wide data", data, exp_line(line));
      end else begin
        chk(int'(idx) == k - first, "R5 word index", LW'(idx), LW'(k - first));
        chk(data == LW'(exp_word(line, k - first)), "R5 R6 word data", data,
            LW'(exp_word(line, k - first)));
      end
    end
  endtask

  // one request; returns at the negedge where both are idle again (R10)
  task automatic run_request(input int line, input bit noise);
    req_valid = 1'b1;
    req_line  = AW'(line);
    for (int k = 2; k <= LAT + NB + 2; k++) begin
      @(negedge clk);
      check_cycle(1'b0, k, line, n_busy, n_valid, n_idx, n_last, n_data, n_pv, n_pc);
      check_cycle(1'b1, k, line, w_busy, w_valid, w_idx, w_last, w_data, w_pv, w_pc);
      // R3: random traffic while both are still busy
      if (noise && k < LAT + 1) begin
        req_valid = 1'($urandom);
        req_line  = AW'($urandom);
      end else begin
        req_valid = 1'b0;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: quiet under reset
    repeat (3) @(negedge clk);
    chk(!n_busy && !n_valid && !n_pv && !n_last, "R1 reset interleaved", LW'(n_busy), '0);
    chk(!w_busy && !w_valid && !w_pv && !w_last, "R1 reset wide", LW'(w_busy), '0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!n_busy && !n_valid && !n_pv, "R1 idle after reset", LW'(n_busy), '0);
    chk(!w_busy && !w_valid && !w_pv, "R1 idle after reset wide", LW'(w_busy), '0);
    // directed corners: lowest and highest line, then back-to-back random (R10)
    run_request(0, 1'b0);
    run_request((1 << AW) - 1, 1'b1);
    for (int n = 0; n < 30; n++) run_request(int'($urandom_range((1 << AW) - 1)), 1'b1);
    @(negedge clk);
    chk(!n_busy && !w_busy, "R7 idle at end", LW'({n_busy, w_busy}), '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule